// File: doc/BRIEF.md
# Data-Link Receive Stack Capture

This block sits behind a receive framer that has already found the 36-frame superframe. The framer hands over, one beat at a time, the framing-pattern bits and the data-link bits it extracts from each superframe. It marks each beat with its kind, pulses a strobe with the beat that closes the superframe, and drives a level that says whether superframe alignment is currently held. The block collects the bits of one superframe in a private shift buffer. When a superframe closes cleanly, it copies the whole buffer in one step into a five-byte stack that a host reads through a simple registered read port.

Each clean capture sets a ready flag, which the host clears by reading the status location. Each capture also drives an interrupt level, gated by an enable pin. The stack is overwritten by every clean superframe, so the host has one superframe period to fetch it. Whenever alignment is missing at any point of a superframe, that superframe is thrown away: the stack keeps its old contents, and neither the flag nor the interrupt is raised.

The bit input is a valid/ready stream that never applies back-pressure. `bit_ready` is held high, and every cycle with `bit_valid` high is one accepted beat. A beat that arrives while alignment is missing is still accepted, but it spoils the superframe it belongs to. The strobe, alignment, enable and read signals are plain control pins.

Top module: `fdl_rx_capture`

## Requirements
- R1: Stack layout. Byte 0 bits 5..0 hold the first six framing-pattern bits received, with the earliest at bit 5. Byte 1 bits 5..0 hold the next six in the same order. Bits 7..6 of bytes 0 and 1 read as zero. Bytes 2, 3 and 4 hold the 24 data-link bits in arrival order, with the earliest at byte 2 bit 7 and the last at byte 4 bit 0.
- R2: A superframe runs from one `sf_end` strobe up to and including the next. It is committed on the closing `sf_end` edge when three conditions hold: `sf_aligned` was high on every cycle of that span, including both strobes; exactly 12 framing-pattern beats were accepted; and exactly 24 data-link beats were accepted. A read issued on the following cycle returns the new stack.
- R3: If alignment is low on any cycle of a superframe, that superframe is discarded. The stack keeps its previous contents and the ready flag is not set. The next superframe that meets R2 is captured normally.
- R4: A superframe whose framing-pattern or data-link beat count differs from 12 or 24 is discarded, as in R3.
- R5: A commit sets the ready flag. Reading address 5 returns the flag in bit 0 (bits 7..1 zero) and clears it. If that read happens on the same edge as a commit, the flag stays set.
- R6: Every commit overwrites the stack whether or not the previous one was read.
- R7: `irq` is high exactly when the ready flag is set and `irq_en` is high.
- R8: A read with `rd_en` high on one edge yields `rd_valid` high and `rd_data` on the next cycle, showing the state before that edge. Addresses 0 to 4 return stack bytes and address 5 returns status. Addresses 6 and 7 return zero. Reading a stack byte leaves the flag unchanged.
- R9: `bit_ready` is always high.
- R10: After reset the stack reads zero, the flag, `irq` and `rd_valid` are low, and the first superframe closed after reset is never captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Beat present on the bit stream |
| bit_ready | output | 1 | Stream ready, always high |
| bit_data | input | 1 | Received bit value |
| bit_is_fs | input | 1 | 1: framing-pattern bit, 0: data-link bit |
| sf_end | input | 1 | Strobe with the last position of a superframe |
| sf_aligned | input | 1 | Superframe alignment held by the framer |
| irq_en | input | 1 | Interrupt enable |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 3 | Read address: 0-4 stack, 5 status |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Interrupt level |

## Verification
The bench targets three kinds of superframe.

- **Alignment dropped for a single beat mid-superframe.** A design that ignores partial losses would overwrite the stack and raise the flag.
- **One beat short.** A design that only counts strobes would commit a misaligned stack.
- **First superframe after reset.** A design without an initial spoil state would capture a superframe it never saw start.

It also places a status read on the same edge as a commit. A design that gives the clear priority loses that capture's flag. Finally, it lets two captures pass unread and then reads the stack. A design that holds data until it is read would return the older contents.

// File: rtl/fdl_rx_pkg.sv
`timescale 1ns/1ps
package fdl_rx_pkg;
  parameter int unsigned FS_BITS_DEF     = 12;
  parameter int unsigned D_BITS_DEF      = 24;
  parameter int unsigned BYTE_W_DEF      = 8;
  parameter int unsigned FS_PER_BYTE_DEF = 6;
endpackage

// File: rtl/fdl_rx_shift.sv
`timescale 1ns/1ps
module fdl_rx_shift #(
  parameter int unsigned FS_BITS = 12,
  parameter int unsigned D_BITS  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              bit_data,
  input  logic              bit_is_fs,
  input  logic              sf_end,
  input  logic              aligned,
  output logic              commit,
  output logic [FS_BITS-1:0] fs_cap,
  output logic [D_BITS-1:0]  d_cap
);
  localparam int unsigned FC_W = $clog2(FS_BITS + 2);
  localparam int unsigned DC_W = $clog2(D_BITS + 2);

  logic [FS_BITS-1:0] fs_q, fs_n;
  logic [D_BITS-1:0]  d_q, d_n;
  logic [FC_W-1:0]    fs_cnt_q, fs_cnt_n;
  logic [DC_W-1:0]    d_cnt_q, d_cnt_n;
  logic               spoil_q, spoil_n;

  always_comb begin
    fs_n     = fs_q;
    d_n      = d_q;
    fs_cnt_n = fs_cnt_q;
    d_cnt_n  = d_cnt_q;
    if (beat && bit_is_fs) begin
      fs_n = {fs_q[FS_BITS-2:0], bit_data};
      if (fs_cnt_q <= FC_W'(FS_BITS)) fs_cnt_n = fs_cnt_q + FC_W'(1);
    end
    if (beat && !bit_is_fs) begin
      d_n = {d_q[D_BITS-2:0], bit_data};
      if (d_cnt_q <= DC_W'(D_BITS)) d_cnt_n = d_cnt_q + DC_W'(1);
    end
    spoil_n = spoil_q | ~aligned;
  end

  assign commit = sf_end && !spoil_n &&
                  (fs_cnt_n == FC_W'(FS_BITS)) && (d_cnt_n == DC_W'(D_BITS));
  assign fs_cap = fs_n;
  assign d_cap  = d_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q     <= '0;
      d_q      <= '0;
      fs_cnt_q <= '0;
      d_cnt_q  <= '0;
      spoil_q  <= 1'b1;
    end else if (sf_end) begin
      fs_q     <= '0;
      d_q      <= '0;
      fs_cnt_q <= '0;
      d_cnt_q  <= '0;
      spoil_q  <= ~aligned;
    end else begin
      fs_q     <= fs_n;
      d_q      <= d_n;
      fs_cnt_q <= fs_cnt_n;
      d_cnt_q  <= d_cnt_n;
      spoil_q  <= spoil_n;
    end
  end
endmodule

// File: rtl/fdl_rx_regs.sv
`timescale 1ns/1ps
module fdl_rx_regs #(
  parameter int unsigned FS_BITS     = 12,
  parameter int unsigned D_BITS      = 24,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned FS_PER_BYTE = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic                   clr_flag,
  input  logic [FS_BITS-1:0]     fs_cap,
  input  logic [D_BITS-1:0]      d_cap,
  output logic [(FS_BITS/FS_PER_BYTE + D_BITS/BYTE_W)*BYTE_W-1:0] stack_flat,
  output logic                   flag
);
  localparam int unsigned FS_BYTES    = FS_BITS / FS_PER_BYTE;
  localparam int unsigned D_BYTES     = D_BITS / BYTE_W;
  localparam int unsigned STACK_BYTES = FS_BYTES + D_BYTES;
  localparam int unsigned PAD_W       = BYTE_W - FS_PER_BYTE;

  logic [STACK_BYTES*BYTE_W-1:0] image;
  logic [STACK_BYTES*BYTE_W-1:0] stack_q;
  logic                          flag_q;

  for (genvar k = 0; k < FS_BYTES; k++) begin : g_fs_byte
    assign image[k*BYTE_W +: BYTE_W] =
      {{PAD_W{1'b0}}, fs_cap[FS_BITS-1-k*FS_PER_BYTE -: FS_PER_BYTE]};
  end
  for (genvar k = 0; k < D_BYTES; k++) begin : g_d_byte
    assign image[(FS_BYTES+k)*BYTE_W +: BYTE_W] =
      d_cap[D_BITS-1-k*BYTE_W -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stack_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (commit) stack_q <= image;
      if (commit)        flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  assign stack_flat = stack_q;
  assign flag       = flag_q;
endmodule

// File: rtl/fdl_rx_hostif.sv
`timescale 1ns/1ps
module fdl_rx_hostif #(
  parameter int unsigned STACK_BYTES = 5,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned ADDR_W      = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [STACK_BYTES*BYTE_W-1:0] stack_flat,
  input  logic                          flag,
  output logic                          clr_flag,
  output logic                          rd_valid,
  output logic [BYTE_W-1:0]             rd_data
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STACK_BYTES);

  logic [BYTE_W-1:0] mux;
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;

  always_comb begin
    mux = '0;
    for (int k = 0; k < STACK_BYTES; k++) begin
      if (rd_addr == ADDR_W'(k)) mux = stack_flat[k*BYTE_W +: BYTE_W];
    end
    if (rd_addr == STAT_A) mux = {{(BYTE_W-1){1'b0}}, flag};
  end

  assign clr_flag = rd_en && (rd_addr == STAT_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) data_q <= mux;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;
endmodule

// File: rtl/fdl_rx_capture.sv
`timescale 1ns/1ps
module fdl_rx_capture import fdl_rx_pkg::*; #(
  parameter  int unsigned FS_BITS     = FS_BITS_DEF,
  parameter  int unsigned D_BITS      = D_BITS_DEF,
  parameter  int unsigned BYTE_W      = BYTE_W_DEF,
  parameter  int unsigned FS_PER_BYTE = FS_PER_BYTE_DEF,
  localparam int unsigned STACK_BYTES = FS_BITS/FS_PER_BYTE + D_BITS/BYTE_W,
  localparam int unsigned ADDR_W      = $clog2(STACK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_data,
  input  logic              bit_is_fs,
  input  logic              sf_end,
  input  logic              sf_aligned,
  input  logic              irq_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq
);
  logic                          commit_w;
  logic                          clr_w;
  logic                          flag_w;
  logic [FS_BITS-1:0]            fs_w;
  logic [D_BITS-1:0]             d_w;
  logic [STACK_BYTES*BYTE_W-1:0] stack_w;

  assign bit_ready = 1'b1;

  fdl_rx_shift #(.FS_BITS(FS_BITS), .D_BITS(D_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .beat(bit_valid && bit_ready),
    .bit_data(bit_data), .bit_is_fs(bit_is_fs), .sf_end(sf_end),
    .aligned(sf_aligned), .commit(commit_w), .fs_cap(fs_w), .d_cap(d_w)
  );

  fdl_rx_regs #(.FS_BITS(FS_BITS), .D_BITS(D_BITS), .BYTE_W(BYTE_W),
                .FS_PER_BYTE(FS_PER_BYTE)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .clr_flag(clr_w),
    .fs_cap(fs_w), .d_cap(d_w), .stack_flat(stack_w), .flag(flag_w)
  );

  fdl_rx_hostif #(.STACK_BYTES(STACK_BYTES), .BYTE_W(BYTE_W),
                  .ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .stack_flat(stack_w), .flag(flag_w), .clr_flag(clr_w),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign irq = flag_w && irq_en;
endmodule

// File: rtl/fdl_rx_capture_chk.sv
`timescale 1ns/1ps
module fdl_rx_capture_chk #(
  parameter int unsigned SW = 40,
  parameter int unsigned AW = 3,
  parameter int unsigned STAT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sf_end,
  input logic          sf_aligned,
  input logic          irq_en,
  input logic          irq,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          bit_ready,
  input logic          commit,
  input logic          flag,
  input logic [SW-1:0] stack_flat
);
  p_commit_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (sf_end && sf_aligned));
  p_no_rise_unaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !sf_aligned) |=> !flag);
  p_stack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(stack_flat));
  p_commit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> flag);
  p_status_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == AW'(STAT) && !commit) |=> !flag);
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && flag));
  p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready);
endmodule

bind fdl_rx_capture fdl_rx_capture_chk #(
  .SW(STACK_BYTES*BYTE_W), .AW(ADDR_W), .STAT(STACK_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sf_end(sf_end), .sf_aligned(sf_aligned),
  .irq_en(irq_en), .irq(irq), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .bit_ready(bit_ready), .commit(commit_w),
  .flag(flag_w), .stack_flat(stack_w)
);

// File: tb/fdl_rx_capture_tb.sv
`timescale 1ns/1ps
module fdl_rx_capture_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0, bit_data = 1'b0, bit_is_fs = 1'b0;
  logic       sf_end = 1'b0, sf_aligned = 1'b1, irq_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic       bit_ready, rd_valid, irq;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fdl_rx_capture u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .bit_is_fs(bit_is_fs), .sf_end(sf_end),
    .sf_aligned(sf_aligned), .irq_en(irq_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  bit         fsq[$];
  bit         dq[$];
  bit         m_spoil;
  logic [7:0] m_stack[5];
  bit         m_flag, m_rdv;
  logic [7:0] m_rdd;

  always @(posedge clk) begin
    if (!rst_n) begin
      fsq.delete(); dq.delete();
      m_spoil = 1; m_flag = 0; m_rdv = 0; m_rdd = 0;
      for (int k = 0; k < 5; k++) m_stack[k] = 0;
    end else begin
      bit spoil_now, done;
      m_rdv = rd_en;
      if (rd_en) begin
        if (rd_addr < 5)       m_rdd = m_stack[rd_addr];
        else if (rd_addr == 5) m_rdd = {7'b0, m_flag};
        else                   m_rdd = 8'h00;
      end
      if (bit_valid) begin
        if (bit_is_fs) fsq.push_back(bit_data);
        else           dq.push_back(bit_data);
      end
      spoil_now = m_spoil | !sf_aligned;
      done = sf_end && !spoil_now && fsq.size() == 12 && dq.size() == 24;
      if (done) begin
        for (int k = 0; k < 5; k++) m_stack[k] = 0;
        for (int j = 0; j < 6; j++) begin
          m_stack[0][5-j] = fsq[j];
          m_stack[1][5-j] = fsq[6+j];
        end
        for (int b = 0; b < 3; b++)
          for (int j = 0; j < 8; j++) m_stack[2+b][7-j] = dq[8*b+j];
      end
      if (sf_end) begin
        fsq.delete(); dq.delete();
        m_spoil = !sf_aligned;
      end else begin
        m_spoil = spoil_now;
      end
      if (done) m_flag = 1;
      else if (rd_en && rd_addr == 5) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 ready", bit_ready, 1);
      chk("R7 irq", irq, m_flag & irq_en);
      chk("R8 rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk("R8 rd_data", rd_data, m_rdd);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic logic [7:0] exp_byte(input logic [11:0] fs, input logic [23:0] d, input int k);
    case (k)
      0: return {2'b00, fs[11:6]};
      1: return {2'b00, fs[5:0]};
      2: return d[23:16];
      3: return d[15:8];
      default: return d[7:0];
    endcase
  endfunction

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_en = 1; rd_addr = a;
    @(posedge clk); #2;
    rd_en = 0;
    @(negedge clk);
    v = rd_data;
    tick();
  endtask

  task automatic send_sf(input logic [11:0] fs, input logic [23:0] d,
                         input int drop_at = -1, input int nbeats = 36,
                         input bit st_rd = 0);
    for (int i = 0; i < nbeats; i++) begin
      bit_valid  = 1;
      bit_is_fs  = (i % 3 == 0);
      bit_data   = bit_is_fs ? fs[11 - i/3] : d[23 - (2*(i/3) + (i%3) - 1)];
      sf_aligned = (i != drop_at);
      sf_end     = (i == nbeats - 1);
      if (st_rd && i == nbeats - 1) begin rd_en = 1; rd_addr = 3'd5; end
      tick();
      rd_en = 0;
      if (i % 7 == 6 && i != nbeats - 1) begin
        bit_valid = 0; sf_end = 0; sf_aligned = 1;
        tick();
      end
    end
    bit_valid = 0; sf_end = 0; sf_aligned = 1;
  endtask

  localparam logic [11:0] FA = 12'hA5C, FB = 12'h123, FC = 12'hFFF, FE = 12'h0C3;
  localparam logic [23:0] DA = 24'h3C96E1, DB = 24'h456789, DC = 24'h0F0F0F, DE = 24'hABCDEF;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(posedge clk);
    #2 rst_n = 1;
    tick();
    chk("R10 rd_valid after reset", rd_valid, 0);
    chk("R10 irq after reset", irq, 0);
    for (int k = 0; k < 6; k++) begin
      rd(k[2:0], v);
      chk("R10 reset readback", v, 0);
    end
    irq_en = 1;
    send_sf(FA, DA);
    chk("R10 first superframe not captured", irq, 0);
    rd(3'd2, v); chk("R10 stack still zero", v, 0);

    send_sf(FA, DA);
    chk("R2 capture raises irq", irq, 1);
    for (int k = 0; k < 5; k++) begin
      rd(k[2:0], v); chk("R1 layout", v, exp_byte(FA, DA, k));
    end
    rd(3'd5, v); chk("R5 status set", v, 1);
    chk("R5 flag cleared", irq, 0);
    rd(3'd5, v); chk("R5 status after clear", v, 0);

    send_sf(FB, DB);
    send_sf(FC, DC);
    rd(3'd5, v); chk("R6 status", v, 1);
    for (int k = 0; k < 5; k++) begin
      rd(k[2:0], v); chk("R6 newest overwrites", v, exp_byte(FC, DC, k));
    end

    send_sf(~FA, ~DA, 10);
    chk("R3 no flag after loss", irq, 0);
    rd(3'd2, v); chk("R3 stack held", v, exp_byte(FC, DC, 2));
    send_sf(FE, DE);
    chk("R3 recovery capture", irq, 1);
    rd(3'd4, v); chk("R3 recovery data", v, exp_byte(FE, DE, 4));
    rd(3'd5, v); chk("R5 status", v, 1);

    send_sf(FA, DA, -1, 35);
    chk("R4 short superframe dropped", irq, 0);
    rd(3'd0, v); chk("R4 stack held", v, exp_byte(FE, DE, 0));

    send_sf(FB, DB);
    irq_en = 0; #1;
    chk("R7 irq masked", irq, 0);
    irq_en = 1; #1;
    chk("R7 irq unmasked", irq, 1);
    rd(3'd6, v); chk("R8 unused address", v, 0);
    rd(3'd0, v); chk("R8 stack byte", v, exp_byte(FB, DB, 0));
    chk("R8 stack read keeps flag", irq, 1);

    send_sf(FC, DC, -1, 36, 1);
    chk("R5 commit beats coincident clear", irq, 1);
    rd(3'd5, v); chk("R5 status after coincident read", v, 1);
    rd(3'd3, v); chk("R2 latest data", v, exp_byte(FC, DC, 3));

    tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule